// File: doc/BRIEF.md
# Converter Start Sequencer with Self-Clearing Start Bit

This block owns the control word of a sampling converter and decides when a conversion runs. A host writes a channel number, a software start bit and an interface-mode bit in one cycle. A separate one-cycle hardware pulse can also request a conversion. Once a conversion is accepted, the block holds busy high through an acquisition interval and then a conversion interval. A counter stands in for the converter's real timing. When busy falls, the block pulses a done event, and the software start bit clears itself.

After reset a calibration phase runs, and busy is high during it. Any write or start request that arrives while busy is high is dropped as a whole. The software start bit therefore cannot be re-armed until busy has fallen.

A write can change the channel and set the start bit at the same time. In that case the acquisition interval belongs to the old channel, so the result is marked invalid. The next conversion on that channel is valid. A host polls the busy bit in the status word, or watches the done event, to learn that a conversion has ended.

Top module: `conv_ctrl_top`

## Requirements
- R1: After reset is released, busy stays high for exactly CAL_CYCLES clock cycles. In that time the channel, the two-wire bit and the start bit all read 0.
- R2: Busy is low and a request arrives: either a write with wr_start=1 or a one-cycle hw_start pulse. Busy then goes high after that clock edge and stays high for exactly ACQ_CYCLES+CONV_CYCLES cycles.
- R3: done_o is high for exactly one cycle, and that cycle is the first cycle in which busy is low again after a conversion. done_o never rises at the end of calibration.
- R4: The start bit (status bit 1) reads 1 from a software-started launch until busy falls, and then reads 0. A hardware start leaves it at 0.
- R5: While busy is high, writes and hw_start are ignored. The channel, the two-wire bit and the start bit keep their values, and no further conversion follows.
- R6: A write that sets wr_start=1 and also carries a channel different from the held one flags its result as invalid. In that case done_bad_o=1 with done_o, and status bit 3 reads 1. Two other cases leave the result valid, giving done_bad_o=0 and status bit 3 = 0: a write of the same channel with start, and a hardware start.
- R7: The two-wire mode bit (status bit 2) takes wr_two_wire on an accepted write. Its reset value is 0, which selects three-wire mode.
- R8: The status word is laid out as follows: bit 0 is busy, bit 1 the start bit, bit 2 the two-wire bit, bit 3 the invalid flag, and bits [CH_W+3:4] the channel. chan_o always equals the held channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used as the converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_chan | input | CH_W | Channel field of the written word |
| wr_start | input | 1 | Software start bit of the written word |
| wr_two_wire | input | 1 | Interface-mode bit of the written word (1 = two-wire) |
| hw_start | input | 1 | Hardware start pulse |
| busy_o | output | 1 | High during calibration, acquisition and conversion |
| status_o | output | CH_W+4 | Status word (layout in R8) |
| done_o | output | 1 | One-cycle end-of-conversion event |
| done_bad_o | output | 1 | High with done_o when the result is invalid |
| chan_o | output | CH_W | Currently selected channel |

## Verification
Every accepted request is captured on the clock edge that samples it, and busy is already high in the following cycle. Busy then stays high for ACQ_CYCLES+CONV_CYCLES cycles. done_o and done_bad_o are registered, so they show in the first cycle in which busy is low. The status word follows the held registers with no further delay. The bench drives inputs and samples outputs only at falling edges. It counts the falling edges at which busy is high and compares that count with the interval sum it computes itself. It checks done and the status word at the first falling edge with busy low. For ignored writes, it reads the channel and mode at the next falling edge.

// File: rtl/conv_ctrl_pkg.sv
package conv_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_CAL  = 2'd0,
    PH_IDLE = 2'd1,
    PH_ACQ  = 2'd2,
    PH_CONV = 2'd3
  } phase_t;

  // status word bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_START = 1;
  localparam int ST_TWO_W = 2;
  localparam int ST_BAD   = 3;
  localparam int ST_CHAN  = 4;

  // length in cycles of a timed phase (idle has none)
  function automatic int phase_len(phase_t ph, int cal, int acq, int conv);
    case (ph)
      PH_CAL:  return cal;
      PH_ACQ:  return acq;
      PH_CONV: return conv;
      default: return 1;
    endcase
  endfunction

  // total busy time of one conversion
  function automatic int conv_busy_len(int acq, int conv);
    return acq + conv;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/conv_ctrl_seq.sv
module conv_ctrl_seq
  import conv_ctrl_pkg::*;
#(
  parameter int CAL_CYCLES  = 64,
  parameter int ACQ_CYCLES  = 2,
  parameter int CONV_CYCLES = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic launch,
  output logic busy,
  output logic busy_fall,
  output logic done
);
  localparam int MAX_LEN = max3(CAL_CYCLES, ACQ_CYCLES, CONV_CYCLES);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_cyc;

  assign last_cyc  = (cnt_q == CNT_W'(phase_len(phase_q, CAL_CYCLES, ACQ_CYCLES, CONV_CYCLES) - 1));
  assign busy      = (phase_q != PH_IDLE);
  assign launch    = (phase_q == PH_IDLE) && start_req;
  assign busy_fall = last_cyc && ((phase_q == PH_CONV) || (phase_q == PH_CAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CAL;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_req) begin
          phase_q <= PH_ACQ;
          cnt_q   <= '0;
        end
      end else if (last_cyc) begin
        cnt_q <= '0;
        case (phase_q)
          PH_CAL:  phase_q <= PH_IDLE;
          PH_ACQ:  phase_q <= PH_CONV;
          default: begin
            phase_q <= PH_IDLE;
            done    <= 1'b1;
          end
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt_q) < phase_len(phase_q, CAL_CYCLES, ACQ_CYCLES, CONV_CYCLES))); // R2
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy); // R2
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
endmodule

// File: rtl/conv_ctrl_regs.sv
module conv_ctrl_regs #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            wr_start,
  input  logic            wr_two_wire,
  input  logic            busy,
  input  logic            launch,
  input  logic            busy_fall,
  output logic [CH_W-1:0] chan,
  output logic            two_wire,
  output logic            start_bit,
  output logic            bad
);
  logic wr_ok;
  logic chan_moves;

  assign wr_ok      = wr_en && !busy;
  assign chan_moves = wr_ok && (wr_chan != chan);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan      <= '0;
      two_wire  <= 1'b0;
      start_bit <= 1'b0;
      bad       <= 1'b0;
    end else begin
      if (wr_ok) begin
        chan     <= wr_chan;
        two_wire <= wr_two_wire;
      end
      if (busy_fall)
        start_bit <= 1'b0;
      else if (wr_ok && wr_start)
        start_bit <= 1'b1;
      if (launch)
        bad <= chan_moves;
    end
  end

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(chan) && $stable(two_wire))); // R5
  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_fall |=> !start_bit); // R4
  AST_START_ARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_bit) |-> $past(!busy)); // R4
  AST_BAD_ONLY_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch) |=> $stable(bad)); // R6
endmodule

// File: rtl/conv_ctrl_top.sv
module conv_ctrl_top
  import conv_ctrl_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int CAL_CYCLES  = 64,
  parameter int ACQ_CYCLES  = 2,
  parameter int CONV_CYCLES = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            wr_start,
  input  logic            wr_two_wire,
  input  logic            hw_start,
  output logic            busy_o,
  output logic [CH_W+3:0] status_o,
  output logic            done_o,
  output logic            done_bad_o,
  output logic [CH_W-1:0] chan_o
);
  logic start_req, launch, busy, busy_fall, done;
  logic two_wire, start_bit, bad;
  logic [CH_W-1:0] chan;

  assign start_req = (wr_en && wr_start) || hw_start;

  conv_ctrl_seq #(
    .CAL_CYCLES (CAL_CYCLES),
    .ACQ_CYCLES (ACQ_CYCLES),
    .CONV_CYCLES(CONV_CYCLES)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .launch   (launch),
    .busy     (busy),
    .busy_fall(busy_fall),
    .done     (done)
  );

  conv_ctrl_regs #(.CH_W(CH_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_chan    (wr_chan),
    .wr_start   (wr_start),
    .wr_two_wire(wr_two_wire),
    .busy       (busy),
    .launch     (launch),
    .busy_fall  (busy_fall),
    .chan       (chan),
    .two_wire   (two_wire),
    .start_bit  (start_bit),
    .bad        (bad)
  );

  always_comb begin
    status_o                      = '0;
    status_o[ST_BUSY]             = busy;
    status_o[ST_START]            = start_bit;
    status_o[ST_TWO_W]            = two_wire;
    status_o[ST_BAD]              = bad;
    status_o[ST_CHAN +: CH_W]     = chan;
  end

  assign busy_o     = busy;
  assign done_o     = done;
  assign done_bad_o = done && bad;
  assign chan_o     = chan;

  AST_DONE_BAD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_bad_o |-> (done_o && status_o[ST_BAD])); // R6
endmodule

// File: tb/conv_ctrl_top_tb_top.sv
module conv_ctrl_top_tb_top;
  localparam int CH_W = 2;
  localparam int CAL  = 6;
  localparam int ACQ  = 2;
  localparam int CONV = 5;
  localparam int LEN  = ACQ + CONV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_start = 1'b0, wr_two_wire = 1'b0, hw_start = 1'b0;
  logic [CH_W-1:0] wr_chan = '0;
  logic busy_o, done_o, done_bad_o;
  logic [CH_W+3:0] status_o;
  logic [CH_W-1:0] chan_o;

  int n_run = 0;
  int n_fail = 0;
  int exp_chan = 0, exp_tw = 0;

  always #10 clk = ~clk;

  conv_ctrl_top #(.CH_W(CH_W), .CAL_CYCLES(CAL), .ACQ_CYCLES(ACQ), .CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_start(wr_start),
    .wr_two_wire(wr_two_wire), .hw_start(hw_start), .busy_o(busy_o), .status_o(status_o),
    .done_o(done_o), .done_bad_o(done_bad_o), .chan_o(chan_o));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stat(int ch, int bad, int tw, int sb, int bz);
    return (ch << 4) | (bad << 3) | (tw << 2) | (sb << 1) | bz;
  endfunction

  // called at a falling edge; one write captured at the next rising edge
  task automatic wr(input int ch, input bit st, input bit tw);
    wr_en = 1'b1; wr_chan = CH_W'(ch); wr_start = st; wr_two_wire = tw;
    @(negedge clk);
    wr_en = 1'b0; wr_start = 1'b0;
  endtask

  task automatic hw_pulse();
    hw_start = 1'b1;
    @(negedge clk);
    hw_start = 1'b0;
  endtask

  task automatic busy_count(output int n);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset status", int'(status_o), stat(0, 0, 0, 0, 1));
    rst_n = 1'b1;
    busy_count(n);
    chk("R1 calibration length", n, CAL);
    chk("R3 no done after calibration", int'(done_o), 0);
    chk("R8 idle status", int'(status_o), stat(0, 0, 0, 0, 0));

    // sweep channels and start sources
    for (int c = 0; c < (1 << CH_W); c++) begin
      for (int h = 0; h < 2; h++) begin
        wr(c, 1'b0, 1'(exp_tw));
        exp_chan = c;
        chk("R8 chan_o after write", int'(chan_o), c);
        if (h == 1) hw_pulse(); else wr(c, 1'b1, 1'(exp_tw));
        chk("R4 start bit during busy", int'(status_o), stat(c, 0, exp_tw, (h == 0) ? 1 : 0, 1));
        busy_count(n);
        chk("R2 busy length", n, LEN);
        chk("R3 done at busy fall", int'(done_o), 1);
        chk("R6 valid result", int'(done_bad_o), 0);
        chk("R4 start bit cleared", int'(status_o), stat(c, 0, exp_tw, 0, 0));
        @(negedge clk);
        chk("R3 done one cycle", int'(done_o), 0);
      end
      exp_tw = c & 1;
      wr(c, 1'b0, 1'(exp_tw));
      chk("R7 two-wire bit", int'(status_o[2]), exp_tw);
    end

    // same-write channel change and start
    wr(1, 1'b1, 1'(exp_tw));
    busy_count(n);
    chk("R6 invalid flagged", int'(done_bad_o), 1);
    chk("R6 invalid in status", int'(status_o), stat(1, 1, exp_tw, 0, 0));
    wr(1, 1'b1, 1'(exp_tw));
    busy_count(n);
    chk("R6 next same channel valid", int'(done_bad_o), 0);
    chk("R6 status cleared", int'(status_o[3]), 0);

    // requests while busy are dropped
    hw_pulse();
    wr(2, 1'b1, 1'(~exp_tw[0]));
    chk("R5 channel held", int'(chan_o), 1);
    chk("R5 mode held", int'(status_o[2]), exp_tw);
    hw_pulse();
    busy_count(n);
    chk("R5 busy length unchanged", n + 2, LEN);
    chk("R5 start bit stays clear", int'(status_o[1]), 0);
    repeat (3) @(negedge clk);
    chk("R5 no extra conversion", int'(busy_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule